// File: doc/BRIEF.md
# Per-Channel Edge Interrupt Controller

This block watches a word of asynchronous digital input lines and turns a chosen transition on each line into a pending event. Software picks rising or falling detection for every channel, and it unmasks the channels it wants to hear from. Each event is kept in a sticky status bit. A single interrupt line is raised while any pending channel is also unmasked. The host reads the status word to learn which channels fired. That same read clears the bits it returned, so one access both services and acknowledges the interrupt.

Each input first passes a two-stage synchroniser and is then compared with its value on the previous cycle. An edge on a masked channel is dropped at once and never recorded. Register access uses simple single-cycle read and write strobes with a word offset. Read data is combinational from the current register contents. Writes and the clearing side effect take effect on the next clock edge.

Top module: `eic_ctrl`

## Requirements
- R1: After reset the polarity word and the enable word read as all zeros (all channels rising, all masked), the status word reads zero and `irq_o` is low.
- R2: A write at offset 0x10 loads the polarity word and a write at offset 0x14 loads the enable word. Reads at those offsets return the stored values, and reads at other unmapped offsets return zero.
- R3: A polarity bit of 0 makes its channel react only to a low-to-high change, and a bit of 1 only to a high-to-low change. The opposite transition sets no status bit.
- R4: An edge that arrives while its enable bit is 0 is discarded. Enabling the channel afterwards does not make it appear in the status word.
- R5: Edges on several enabled channels in the same cycle each set their own status bit (bit n for channel n) without disturbing the others.
- R6: A read at offset 0x20 returns the pending status bits and clears every returned bit on the following clock edge. Status bits otherwise stay set.
- R7: An edge whose event falls in the same cycle as a clearing status read leaves its bit set, so the next status read reports it.
- R8: `irq_o` is high exactly when some status bit is set and its enable bit is 1. Clearing the enable bit of a pending channel lowers `irq_o` but keeps the status bit, and re-enabling raises `irq_o` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lines_i | input | 32 | Asynchronous input lines, one per channel |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| addr_i | input | 6 | Byte offset of the accessed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the offset on `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The stimulus covers a lone rising edge, a falling edge preceded by an ignored rising edge on the same line, and a burst of simultaneous rises across five channels with one of them masked. These patterns separate a wrong polarity sense, a missing mask gate and cross-channel interference. A further edge is timed so that its event lands in the same cycle as a clearing read, which tells set-wins from clear-wins priority. Toggling the enable bit of a pending high channel shows whether the interrupt follows the live mask while the status bit is kept.

// File: rtl/eic_pkg.sv
package eic_pkg;
  parameter int unsigned EIC_CH     = 32;
  parameter int unsigned EIC_ADDR_W = 6;
  localparam logic [EIC_ADDR_W-1:0] OFS_POL    = 6'h10;
  localparam logic [EIC_ADDR_W-1:0] OFS_ENA    = 6'h14;
  localparam logic [EIC_ADDR_W-1:0] OFS_STATUS = 6'h20;
endpackage

// File: rtl/eic_rst_sync.sv
module eic_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (s == 0) begin : g_first
        assign src = d_i;
      end else begin : g_rest
        assign src = chain_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= src;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eic_edge_detect.sv
module eic_edge_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] ev_o
);
  logic [WIDTH-1:0] prev_q, prev_d;
  logic [WIDTH-1:0] ev_d;

  always_comb begin
    prev_d = lvl_i;
    // Invert by polarity so a falling edge looks like a rising one
    ev_d = (lvl_i ^ pol_i) & ~(prev_q ^ pol_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  assign ev_o = ev_d;

  AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_o & $past(ev_o) & ~(pol_i ^ $past(pol_i))) == '0)); // R3
endmodule

// File: rtl/eic_status.sv
module eic_status #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stat_q, stat_d;
  logic             upd_en;

  always_comb begin
    upd_en = clr_i | (|set_i);
    stat_d = stat_q;
    if (upd_en) begin
      // Set has priority over clear for the same bit
      stat_d = (clr_i ? '0 : stat_q) | set_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign q_o = stat_q;

  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == $past(set_i))); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o))); // R6
endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int unsigned N_CH    = EIC_CH,
  parameter int unsigned ADDR_W  = EIC_ADDR_W,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   lines_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_CH-1:0]   wdata_i,
  output logic [N_CH-1:0]   rdata_o,
  output logic              irq_o
);
  logic              rst_n;
  logic [N_CH-1:0]   lines_sync;
  logic [N_CH-1:0]   edge_ev;
  logic [N_CH-1:0]   stat;
  logic [N_CH-1:0]   pol_q, pol_d;
  logic [N_CH-1:0]   ena_q, ena_d;
  logic              pol_we, ena_we, stat_clr;
  logic [N_CH-1:0]   accept;

  eic_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n)
  );

  eic_sync #(.WIDTH(N_CH), .STAGES(SYNC_ST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (lines_i),
    .q_o    (lines_sync)
  );

  eic_edge_detect #(.WIDTH(N_CH)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .lvl_i  (lines_sync),
    .pol_i  (pol_q),
    .ev_o   (edge_ev)
  );

  always_comb begin
    accept   = edge_ev & ena_q;
    stat_clr = rd_en_i && (addr_i == OFS_STATUS);
  end

  eic_status #(.WIDTH(N_CH)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .set_i  (accept),
    .clr_i  (stat_clr),
    .q_o    (stat)
  );

  // Configuration registers: next state
  always_comb begin
    pol_we = wr_en_i && (addr_i == OFS_POL);
    ena_we = wr_en_i && (addr_i == OFS_ENA);
    pol_d  = pol_q;
    ena_d  = ena_q;
    if (pol_we) pol_d = wdata_i;
    if (ena_we) ena_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      ena_q <= '0;
    end else begin
      pol_q <= pol_d;
      ena_q <= ena_d;
    end
  end

  // Read mux
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        OFS_POL:    rdata_o = pol_q;
        OFS_ENA:    rdata_o = ena_q;
        OFS_STATUS: rdata_o = stat;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(stat & ena_q);

  AST_MASKED_NOT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(ena_q)) == '0)); // R4
  AST_IRQ_DROPS_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stat_clr && (accept == '0)) |=> !irq_o); // R8
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (stat != '0)); // R8
endmodule

// File: tb/eic_ctrl_tb.sv
module eic_ctrl_tb_top;
  import eic_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  eic_ctrl dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .lines_i (lines),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  // Monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_en) begin
      logic [31:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected read, actual=%h expected=<none>", "scoreboard", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic do_read(input logic [5:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic check_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check_irq(1'b0, "R1");
    do_read(OFS_POL, 32'h0, "R1");
    do_read(OFS_ENA, 32'h0, "R1");
    do_read(OFS_STATUS, 32'h0, "R1");

    // R4 edge while masked is dropped
    lines[3] = 1'b1;
    idle(5);
    do_write(OFS_ENA, 32'h0000_00FF);
    idle(2);
    do_read(OFS_STATUS, 32'h0, "R4");
    check_irq(1'b0, "R4");

    // R2 readback and unmapped offset
    do_read(OFS_ENA, 32'h0000_00FF, "R2");
    do_read(OFS_POL, 32'h0, "R2");
    do_read(6'h08, 32'h0, "R2");

    // R3/R6 rising edge on channel 0, clear on read
    lines[0] = 1'b1;
    idle(5);
    check_irq(1'b1, "R8");
    do_read(OFS_STATUS, 32'h0000_0001, "R6");
    check_irq(1'b0, "R6");
    do_read(OFS_STATUS, 32'h0, "R6");

    // R3 falling polarity on channel 1: rise ignored, fall latched
    do_write(OFS_POL, 32'h0000_0002);
    lines[1] = 1'b1;
    idle(5);
    do_read(OFS_STATUS, 32'h0, "R3");
    lines[1] = 1'b0;
    idle(5);
    do_read(OFS_STATUS, 32'h0000_0002, "R3");

    // R5 simultaneous rises on channels 4..8, channel 8 masked
    lines[8:4] = 5'h1F;
    idle(5);
    do_read(OFS_STATUS, 32'h0000_00F0, "R5");

    // R7 edge event coincides with clearing read
    @(posedge clk); #1;
    lines[2] = 1'b1;
    @(posedge clk);
    do_read(OFS_STATUS, 32'h0, "R7");
    do_read(OFS_STATUS, 32'h0000_0004, "R7");

    // R8 live mask gates irq, status kept
    do_write(OFS_POL, 32'h8000_0002);
    do_write(OFS_ENA, 32'h8000_00FF);
    do_read(OFS_POL, 32'h8000_0002, "R2");
    lines[31] = 1'b1;
    idle(5);
    check_irq(1'b0, "R3");
    lines[31] = 1'b0;
    idle(5);
    check_irq(1'b1, "R8");
    do_write(OFS_ENA, 32'h0000_00FF);
    check_irq(1'b0, "R8");
    do_write(OFS_ENA, 32'h8000_00FF);
    check_irq(1'b1, "R8");
    do_read(OFS_STATUS, 32'h8000_0000, "R8");
    check_irq(1'b0, "R8");

    idle(2);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule